// File: doc/BRIEF.md
# Parallel Flash Identification Probe

This block lets a host controller identify the parallel flash device on its bus without software involvement. A one-cycle `start` pulse launches the probe. The engine first unlocks the device and switches it into identification mode. It then waits an entry delay and reads the vendor and device code bytes. A code byte of 0x7F is a continuation marker, so the engine fetches one more byte from a second bank of ID locations and builds a 16-bit code.

After that the engine sends the leave-identification command and waits an exit delay. It reads the same locations again in normal array mode. A device that never entered identification mode returns the same bytes in both passes, and the engine flags any code that matches the array data. At the end it compares both codes with the expected values on its input ports, checks the vendor byte for odd parity, registers every result and pulses `done`.

The bus side is a simple request/acknowledge master that performs one byte access per acknowledge. The delay mode is latched at start. It selects an explicit cycle count, no wait, or built-in defaults, and its fourth value refuses to touch the bus.

Top module: `flash_id_probe`

## Requirements
- R1: A probe begins with three bus writes, in this order: 0xAA to address 0x5555, then 0x55 to 0x2AAA, then 0x90 to 0x5555.
- R2: After the identification reads, the engine issues three writes: 0xAA to 0x5555, then 0x55 to 0x2AAA, then 0xF0 to 0x5555.
- R3: After the first and the second write of each command, the bus stays idle for between GAP_CYC and GAP_CYC+8 cycles before the next access starts.
- R4: The delay mode is read from `tmg_sel` at start. With `tmg_sel`=00, the bus stays idle for between N and N+8 cycles after the 0x90 write and after the 0xF0 write, where N = `tmg_cycles`. With 01, N = 0 for both. With 10, N = DEF_ENTER_CYC after entry and N = DEF_EXIT_CYC after exit.
- R5: With `tmg_sel`=11 the engine makes no bus access. It pulses `done` with `aborted`=1, `id_match`=0 and both ID outputs at zero.
- R6: In each read pass the engine reads 0x000 (vendor), then 0x001 (device). It then reads 0x100 if the vendor byte was 0x7F, and then 0x101 if the device byte was 0x7F. A code is {0x7F, extra byte} after a continuation and {0x00, byte} otherwise. `mfr_id` and `dev_id` carry the codes from the identification pass.
- R7: After the exit command, the same reads are repeated in array mode. `mfr_is_array` is 1 exactly when the array-mode vendor code equals `mfr_id`, and `dev_is_array` is 1 exactly when the array-mode device code equals `dev_id`.
- R8: `parity_bad` is 1 exactly when bits [7:0] of `mfr_id` hold an even number of ones.
- R9: `id_match` is 1 exactly when `mfr_id` equals `exp_mfr` and `dev_id` equals `exp_dev`. Both expected values are held stable during a probe.
- R10: `bus_req` stays high, with `bus_addr`, `bus_we` and `bus_wdata` stable, until a cycle with `bus_ack` high. It is low in the following cycle.
- R11: After reset, `busy`, `done`, `bus_req` and all result outputs are 0. `done` is a one-cycle pulse, and the results hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a probe (sampled while idle) |
| tmg_sel | input | 2 | Delay mode: 00 cycles, 01 none, 10 defaults, 11 invalid |
| tmg_cycles | input | CNT_W | Entry/exit wait in cycles for mode 00 |
| exp_mfr | input | 16 | Expected vendor code |
| exp_dev | input | 16 | Expected device code |
| bus_req | output | 1 | Access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access accepted/completed |
| bus_rdata | input | 8 | Read data, valid with `bus_ack` |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| aborted | output | 1 | Last probe refused because of an invalid delay mode |
| mfr_id | output | 16 | Assembled vendor code |
| dev_id | output | 16 | Assembled device code |
| id_match | output | 1 | Both codes equal the expected values |
| parity_bad | output | 1 | Vendor byte fails the odd-parity check |
| mfr_is_array | output | 1 | Vendor code equals the array-mode data |
| dev_is_array | output | 1 | Device code equals the array-mode data |

## Verification
The bench sweeps all 256 vendor byte values. This exercises the parity flag on every input, and 0x7F also triggers the continuation path. A parity check with the wrong sense, or one that looks at the high byte, would flag the wrong half of the values. It runs all four continuation combinations and checks the exact read-address order. A design that tests the wrong slot, or always fetches the extra bytes, would show an extra or missing access and a wrong high byte. It measures the idle gap after every command write under each delay mode, which exposes swapped entry and exit defaults or a missing short gap. It also covers a device that ignores identification mode, a device whose array data matches only one code, and the invalid mode, where any bus activity or a stale match is reported.

// File: rtl/fip_pkg.sv
package fip_pkg;
  typedef enum logic [1:0] {
    TM_CYCLES  = 2'b00,
    TM_NONE    = 2'b01,
    TM_DEFAULT = 2'b10,
    TM_INVALID = 2'b11
  } tmode_t;

  typedef enum logic [1:0] {
    PH_ENTER = 2'd0,
    PH_IDRD  = 2'd1,
    PH_LEAVE = 2'd2,
    PH_ARRRD = 2'd3
  } phase_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISSUE, ST_WAIT, ST_PAUSE, ST_NEXT, ST_FIN
  } state_t;

  localparam logic [15:0] UNLOCK_ADDR1 = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR2 = 16'h2AAA;
  localparam logic [7:0]  KEY_FIRST    = 8'hAA;
  localparam logic [7:0]  KEY_SECOND   = 8'h55;
  localparam logic [7:0]  CMD_ID_ON    = 8'h90;
  localparam logic [7:0]  CMD_ID_OFF   = 8'hF0;
  localparam logic [7:0]  CONT_CODE    = 8'h7F;
  localparam logic [15:0] BANK_OFFSET  = 16'h0100;
endpackage

// File: rtl/fip_bus_master.sv
module fip_bus_master #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic              xfer_done,
  output logic [7:0]        rdata_q,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      xfer_done <= 1'b0;
      rdata_q   <= '0;
    end else begin
      xfer_done <= 1'b0;
      if (!bus_req && go) begin
        bus_req   <= 1'b1;
        bus_we    <= we;
        bus_addr  <= addr;
        bus_wdata <= wdata;
      end else if (bus_req && bus_ack) begin
        bus_req   <= 1'b0;
        xfer_done <= 1'b1;
        rdata_q   <= bus_rdata;
      end
    end
  end
endmodule

// File: rtl/fip_delay_timer.sv
module fip_delay_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                remain <= '0;
    else if (load)          remain <= load_val;
    else if (remain != '0)  remain <= remain - 1'b1;
  end

  assign expired = (remain == '0);
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe #(
  parameter int ADDR_W        = 16,
  parameter int CNT_W         = 16,
  parameter int GAP_CYC       = 8,
  parameter int DEF_ENTER_CYC = 2500,
  parameter int DEF_EXIT_CYC  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        tmg_sel,
  input  logic [CNT_W-1:0]  tmg_cycles,
  input  logic [15:0]       exp_mfr,
  input  logic [15:0]       exp_dev,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [7:0]        bus_wdata,
  input  logic              bus_ack,
  input  logic [7:0]        bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              aborted,
  output logic [15:0]       mfr_id,
  output logic [15:0]       dev_id,
  output logic              id_match,
  output logic              parity_bad,
  output logic              mfr_is_array,
  output logic              dev_is_array
);
  import fip_pkg::*;

  localparam logic [CNT_W-1:0] GAP_V   = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] ENTER_V = CNT_W'(DEF_ENTER_CYC);
  localparam logic [CNT_W-1:0] EXIT_V  = CNT_W'(DEF_EXIT_CYC);

  state_t           state;
  phase_t           ph;
  logic [1:0]       step;
  tmode_t           mode_q;
  logic [CNT_W-1:0] cyc_q;
  logic [15:0]      cap [2][2];

  logic             go, is_wr, pass, slot, xfer_done, tmr_load, expired;
  logic [ADDR_W-1:0] op_addr;
  logic [7:0]       op_wdata, rd_byte;
  logic [CNT_W-1:0] tmr_val, enter_dly, exit_dly;
  logic             need_a, need_b;

  assign is_wr = ~ph[0];
  assign pass  = ph[1];
  assign slot  = step[0];
  assign go    = (state == ST_ISSUE);
  assign busy  = (state != ST_IDLE);

  always_comb begin
    op_wdata = '0;
    if (is_wr) begin
      case (step)
        2'd0:    begin op_addr = ADDR_W'(UNLOCK_ADDR1); op_wdata = KEY_FIRST;  end
        2'd1:    begin op_addr = ADDR_W'(UNLOCK_ADDR2); op_wdata = KEY_SECOND; end
        default: begin
          op_addr  = ADDR_W'(UNLOCK_ADDR1);
          op_wdata = (ph == PH_ENTER) ? CMD_ID_ON : CMD_ID_OFF;
        end
      endcase
    end else begin
      op_addr = ADDR_W'({14'd0, step[0]} | (step[1] ? BANK_OFFSET : 16'h0000));
    end
  end

  always_comb begin
    case (mode_q)
      TM_CYCLES:  begin enter_dly = cyc_q;   exit_dly = cyc_q;  end
      TM_DEFAULT: begin enter_dly = ENTER_V; exit_dly = EXIT_V; end
      default:    begin enter_dly = '0;      exit_dly = '0;     end
    endcase
    if (step == 2'd2) tmr_val = (ph == PH_ENTER) ? enter_dly : exit_dly;
    else              tmr_val = GAP_V;
  end

  assign tmr_load = (state == ST_WAIT) && xfer_done && is_wr;
  assign need_a   = (cap[pass][0] == {8'h00, CONT_CODE});
  assign need_b   = (cap[pass][1] == {8'h00, CONT_CODE});

  fip_bus_master #(.ADDR_W(ADDR_W)) bus_i (
    .clk(clk), .rst(rst), .go(go), .we(is_wr), .addr(op_addr),
    .wdata(op_wdata), .xfer_done(xfer_done), .rdata_q(rd_byte),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  fip_delay_timer #(.CNT_W(CNT_W)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      ph    <= PH_ENTER;
      step  <= '0;
      mode_q <= TM_NONE;
      cyc_q <= '0;
      done  <= 1'b0;
      aborted <= 1'b0;
      mfr_id <= '0;
      dev_id <= '0;
      id_match <= 1'b0;
      parity_bad <= 1'b0;
      mfr_is_array <= 1'b0;
      dev_is_array <= 1'b0;
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 2; s++) cap[p][s] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          mode_q <= tmode_t'(tmg_sel);
          cyc_q  <= tmg_cycles;
          ph     <= PH_ENTER;
          step   <= '0;
          if (tmode_t'(tmg_sel) == TM_INVALID) begin
            aborted <= 1'b1;
            mfr_id <= '0;
            dev_id <= '0;
            id_match <= 1'b0;
            parity_bad <= 1'b0;
            mfr_is_array <= 1'b0;
            dev_is_array <= 1'b0;
            done <= 1'b1;
          end else begin
            state <= ST_ISSUE;
          end
        end
        ST_ISSUE: state <= ST_WAIT;
        ST_WAIT: if (xfer_done) begin
          if (is_wr) begin
            state <= ST_PAUSE;
          end else begin
            if (step[1]) cap[pass][slot] <= {cap[pass][slot][7:0], rd_byte};
            else         cap[pass][slot] <= {8'h00, rd_byte};
            state <= ST_NEXT;
          end
        end
        ST_PAUSE: if (expired) begin
          if (step == 2'd2) begin
            ph   <= phase_t'(ph + 2'd1);
            step <= '0;
          end else begin
            step <= step + 2'd1;
          end
          state <= ST_ISSUE;
        end
        ST_NEXT: begin
          state <= ST_ISSUE;
          if (step == 2'd0)                  step <= 2'd1;
          else if (step == 2'd1 && need_a)   step <= 2'd2;
          else if (step != 2'd3 && need_b)   step <= 2'd3;
          else if (!pass) begin
            ph   <= PH_LEAVE;
            step <= '0;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_FIN: begin
          aborted      <= 1'b0;
          mfr_id       <= cap[0][0];
          dev_id       <= cap[0][1];
          id_match     <= (cap[0][0] == exp_mfr) && (cap[0][1] == exp_dev);
          parity_bad   <= ~(^cap[0][0][7:0]);
          mfr_is_array <= (cap[1][0] == cap[0][0]);
          dev_is_array <= (cap[1][1] == cap[0][1]);
          done         <= 1'b1;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fip_checker.sv
module fip_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_ack,
  input logic              busy,
  input logic              done,
  input logic              aborted,
  input logic [15:0]       mfr_id,
  input logic [15:0]       dev_id,
  input logic [15:0]       exp_mfr,
  input logic [15:0]       exp_dev,
  input logic              id_match
);
  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata));

  a_r10_release_after_ack: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_ack |=> !bus_req);

  a_r11_done_single_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req);

  a_r5_abort_no_match: assert property (@(posedge clk) disable iff (rst)
    done && aborted |-> !id_match && mfr_id == 16'h0 && dev_id == 16'h0);

  a_r6_upper_byte_form: assert property (@(posedge clk) disable iff (rst)
    done && !aborted |-> (mfr_id[15:8] == 8'h00 || mfr_id[15:8] == 8'h7F) &&
                         (dev_id[15:8] == 8'h00 || dev_id[15:8] == 8'h7F));

  a_r9_match_means_equal: assert property (@(posedge clk) disable iff (rst)
    done && id_match |-> mfr_id == exp_mfr && dev_id == exp_dev);
endmodule

bind flash_id_probe fip_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
  .busy(busy), .done(done), .aborted(aborted), .mfr_id(mfr_id),
  .dev_id(dev_id), .exp_mfr(exp_mfr), .exp_dev(exp_dev), .id_match(id_match)
);

// File: tb/flash_id_probe_tb_top.sv
module flash_id_probe_tb_top;
  localparam int GAP = 6;
  localparam int DEN = 300;
  localparam int DEX = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] tmg_sel = 2'b01;
  logic [15:0] tmg_cycles = '0;
  logic [15:0] exp_mfr = '0, exp_dev = '0;
  logic bus_req, bus_we, bus_ack;
  logic [15:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic busy, done, aborted, id_match, parity_bad, mfr_is_array, dev_is_array;
  logic [15:0] mfr_id, dev_id;

  always #2 clk = ~clk;

  flash_id_probe #(.ADDR_W(16), .CNT_W(16), .GAP_CYC(GAP),
                   .DEF_ENTER_CYC(DEN), .DEF_EXIT_CYC(DEX)) dut_i (
    .clk(clk), .rst(rst), .start(start), .tmg_sel(tmg_sel),
    .tmg_cycles(tmg_cycles), .exp_mfr(exp_mfr), .exp_dev(exp_dev),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .busy(busy), .done(done), .aborted(aborted), .mfr_id(mfr_id),
    .dev_id(dev_id), .id_match(id_match), .parity_bad(parity_bad),
    .mfr_is_array(mfr_is_array), .dev_is_array(dev_is_array)
  );

  // ---------------- flash device model ----------------
  logic [7:0] m0, m1, c0, c1, a0, a1, a2, a3;
  bit ignore_id = 0;
  logic id_mode;
  int   ucnt;
  int   nlog;
  logic        log_we   [64];
  logic [15:0] log_addr [64];
  logic [7:0]  log_data [64];
  int          log_gap  [64];
  int   low_cnt, cur_gap;
  logic req_d;

  function automatic logic [7:0] dev_read(input logic [15:0] a, input logic idm);
    if (idm) begin
      case (a)
        16'h0000: return m0;
        16'h0001: return m1;
        16'h0100: return c0;
        16'h0101: return c1;
        default:  return 8'hEE;
      endcase
    end
    case (a)
      16'h0000: return a0;
      16'h0001: return a1;
      16'h0100: return a2;
      16'h0101: return a3;
      default:  return 8'hFF;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      bus_ack <= 1'b0; bus_rdata <= '0; id_mode <= 1'b0; ucnt <= 0;
      nlog <= 0; low_cnt <= 0; cur_gap <= 0; req_d <= 1'b0;
    end else begin
      req_d <= bus_req;
      if (!bus_req) low_cnt <= low_cnt + 1;
      if (bus_req && !req_d) begin cur_gap <= low_cnt; low_cnt <= 0; end
      bus_ack <= bus_req && !bus_ack;
      if (bus_req && !bus_ack) begin
        if (bus_we) begin
          if (ucnt == 0)
            ucnt <= (bus_addr == 16'h5555 && bus_wdata == 8'hAA) ? 1 : 0;
          else if (ucnt == 1)
            ucnt <= (bus_addr == 16'h2AAA && bus_wdata == 8'h55) ? 2 : 0;
          else begin
            if (bus_addr == 16'h5555 && bus_wdata == 8'h90 && !ignore_id) id_mode <= 1'b1;
            if (bus_addr == 16'h5555 && bus_wdata == 8'hF0) id_mode <= 1'b0;
            ucnt <= 0;
          end
        end else begin
          bus_rdata <= dev_read(bus_addr, id_mode);
        end
      end
      if (bus_req && bus_ack) begin
        log_we[nlog[5:0]]   <= bus_we;
        log_addr[nlog[5:0]] <= bus_addr;
        log_data[nlog[5:0]] <= bus_we ? bus_wdata : bus_rdata;
        log_gap[nlog[5:0]]  <= cur_gap;
        nlog <= nlog + 1;
      end
    end
  end

  // ---------------- checking ----------------
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] assemble(input logic [7:0] b, input logic [7:0] x);
    return (b == 8'h7F) ? {8'h7F, x} : {8'h00, b};
  endfunction

  function automatic int lg(input int base, input int k);
    return (base + k) & 63;
  endfunction

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  // mism: 0 = expected values match, 1 = vendor wrong, 2 = device wrong
  task automatic probe(input logic [1:0] sel, input int cyc, input int mism);
    logic [7:0] e0, e1, x0, x1;
    logic [15:0] em, ed, am, ad;
    int nid, narr, base, idx, ones, den, dex;
    bit ok;
    logic [15:0] ra [4];
    e0 = ignore_id ? a0 : m0;  e1 = ignore_id ? a1 : m1;
    x0 = ignore_id ? a2 : c0;  x1 = ignore_id ? a3 : c1;
    em = assemble(e0, x0);  ed = assemble(e1, x1);
    am = assemble(a0, a2);  ad = assemble(a1, a3);
    nid  = 2 + (e0 == 8'h7F ? 1 : 0) + (e1 == 8'h7F ? 1 : 0);
    narr = 2 + (a0 == 8'h7F ? 1 : 0) + (a1 == 8'h7F ? 1 : 0);
    den = (sel == 2'b00) ? cyc : (sel == 2'b10) ? DEN : 0;
    dex = (sel == 2'b00) ? cyc : (sel == 2'b10) ? DEX : 0;
    @(negedge clk);
    exp_mfr = (mism == 1) ? em ^ 16'h8000 : em;
    exp_dev = (mism == 2) ? ed ^ 16'h0001 : ed;
    tmg_sel = sel; tmg_cycles = 16'(cyc);
    base = nlog;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok, "R11 done pulse arrives", ok, 1);
    if (!ok) return;
    chk(nlog - base == 6 + nid + narr, "R6 access count", nlog - base, 6 + nid + narr);
    // R1 entry sequence
    chk(log_we[lg(base,0)] && log_addr[lg(base,0)] == 16'h5555 && log_data[lg(base,0)] == 8'hAA,
        "R1 first write", {log_addr[lg(base,0)], log_data[lg(base,0)]}, 24'h5555AA);
    chk(log_we[lg(base,1)] && log_addr[lg(base,1)] == 16'h2AAA && log_data[lg(base,1)] == 8'h55,
        "R1 second write", {log_addr[lg(base,1)], log_data[lg(base,1)]}, 24'h2AAA55);
    chk(log_we[lg(base,2)] && log_addr[lg(base,2)] == 16'h5555 && log_data[lg(base,2)] == 8'h90,
        "R1 third write", {log_addr[lg(base,2)], log_data[lg(base,2)]}, 24'h555590);
    // R2 exit sequence
    idx = 3 + nid;
    chk(log_we[lg(base,idx)] && log_addr[lg(base,idx)] == 16'h5555 && log_data[lg(base,idx)] == 8'hAA,
        "R2 first exit write", {log_addr[lg(base,idx)], log_data[lg(base,idx)]}, 24'h5555AA);
    chk(log_we[lg(base,idx+1)] && log_addr[lg(base,idx+1)] == 16'h2AAA && log_data[lg(base,idx+1)] == 8'h55,
        "R2 second exit write", {log_addr[lg(base,idx+1)], log_data[lg(base,idx+1)]}, 24'h2AAA55);
    chk(log_we[lg(base,idx+2)] && log_addr[lg(base,idx+2)] == 16'h5555 && log_data[lg(base,idx+2)] == 8'hF0,
        "R2 third exit write", {log_addr[lg(base,idx+2)], log_data[lg(base,idx+2)]}, 24'h5555F0);
    // R3 short gaps
    chk(log_gap[lg(base,1)] >= GAP && log_gap[lg(base,1)] <= GAP + 8, "R3 gap after key 1",
        log_gap[lg(base,1)], GAP);
    chk(log_gap[lg(base,2)] >= GAP && log_gap[lg(base,2)] <= GAP + 8, "R3 gap after key 2",
        log_gap[lg(base,2)], GAP);
    chk(log_gap[lg(base,idx+1)] >= GAP && log_gap[lg(base,idx+1)] <= GAP + 8, "R3 exit gap after key 1",
        log_gap[lg(base,idx+1)], GAP);
    // R4 entry and exit waits
    chk(log_gap[lg(base,3)] >= den && log_gap[lg(base,3)] <= den + 8, "R4 entry wait",
        log_gap[lg(base,3)], den);
    chk(log_gap[lg(base,idx+3)] >= dex && log_gap[lg(base,idx+3)] <= dex + 8, "R4 exit wait",
        log_gap[lg(base,idx+3)], dex);
    // R6 read order in both passes
    for (int p = 0; p < 2; p++) begin
      int st, n;
      logic f0, f1;
      st = (p == 0) ? 3 : idx + 3;
      f0 = (p == 0) ? (e0 == 8'h7F) : (a0 == 8'h7F);
      f1 = (p == 0) ? (e1 == 8'h7F) : (a1 == 8'h7F);
      n = 0;
      ra[n++] = 16'h0000; ra[n++] = 16'h0001;
      if (f0) ra[n++] = 16'h0100;
      if (f1) ra[n++] = 16'h0101;
      for (int k = 0; k < n; k++)
        chk(!log_we[lg(base,st+k)] && log_addr[lg(base,st+k)] == ra[k],
            (p == 0) ? "R6 id read address" : "R7 array read address",
            log_addr[lg(base,st+k)], ra[k]);
    end
    chk(mfr_id == em, "R6 vendor code", mfr_id, em);
    chk(dev_id == ed, "R6 device code", dev_id, ed);
    chk(mfr_is_array == (am == em), "R7 vendor array flag", mfr_is_array, am == em);
    chk(dev_is_array == (ad == ed), "R7 device array flag", dev_is_array, ad == ed);
    ones = 0;
    for (int b = 0; b < 8; b++) ones += em[b];
    chk(parity_bad == ((ones % 2) == 0), "R8 parity flag", parity_bad, (ones % 2) == 0);
    chk(id_match == (mism == 0), "R9 match flag", id_match, mism == 0);
    chk(!aborted, "R5 aborted clear on good run", aborted, 0);
    @(negedge clk);
    chk(!done && mfr_id == em, "R11 single pulse and hold", {done, mfr_id}, {1'b0, em});
  endtask

  initial begin
    bit ok;
    int base;
    m0 = 8'h01; m1 = 8'h34; c0 = 8'h9D; c1 = 8'h11;
    a0 = 8'hFF; a1 = 8'hFF; a2 = 8'hFF; a3 = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !bus_req && !id_match && mfr_id == 0 && dev_id == 0 &&
        !parity_bad && !aborted && !mfr_is_array && !dev_is_array,
        "R11 reset state", {busy, done, bus_req, id_match}, 0);

    // R5 invalid mode: no bus access, no match
    probe(2'b01, 0, 0);
    base = nlog;
    @(negedge clk);
    tmg_sel = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && aborted && !id_match && mfr_id == 0 && dev_id == 0, "R5 abort result",
        {done, aborted, id_match}, 3'b110);
    repeat (10) @(negedge clk);
    chk(nlog == base && !busy, "R5 no bus access on abort", nlog - base, 0);

    // R8/R9/R6 sweep of every vendor byte
    for (int v = 0; v < 256; v++) begin
      m0 = 8'(v);
      probe(2'b01, 0, v % 3);
    end

    // R6 continuation combinations with explicit delay
    for (int k = 0; k < 4; k++) begin
      m0 = k[0] ? 8'h7F : 8'h12;
      m1 = k[1] ? 8'h7F : 8'h56;
      probe(2'b00, 20, 0);
    end

    // R7 device that ignores identification mode
    ignore_id = 1;
    a0 = 8'h7F; a1 = 8'h22; a2 = 8'h1F; a3 = 8'hFF;
    probe(2'b01, 0, 0);
    ignore_id = 0;

    // R7 only the vendor code coincides with array data
    m0 = 8'hBF; m1 = 8'h7F; c1 = 8'h05;
    a0 = 8'hBF; a1 = 8'h7F; a3 = 8'h06;
    probe(2'b01, 0, 2);

    // R4 default delays and a larger explicit delay
    a0 = 8'hFF; a1 = 8'hFF; a3 = 8'hFF;
    m0 = 8'h20; m1 = 8'h7F; c1 = 8'h44;
    probe(2'b10, 0, 0);
    probe(2'b00, 123, 1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule